// File: doc/BRIEF.md
# Flash Command Decoder with Busy Status

This block is the synchronous control logic of a word-wide, sector-erasable flash memory. It receives decoded bus cycles: a read strobe, a write strobe, a 16-bit address and 16-bit write data. From these it recognises two-step command sequences. A sector erase takes a setup write followed by an execute write. A word program takes a setup write followed by an address/data write. It also recognises an abort word and an identification mode that returns two fixed code words. The array itself sits outside the block and is reached through a plain port: a combinational read word, a program strobe, an erase strobe, an operation address and an operation data word.

Program and erase are self-timed. A down-counter, loaded with a parameterised cycle count, keeps the matching strobe high and the operation address and data steady. When the count runs out, the block returns to read mode and raises a one-cycle completion pulse. While an operation runs, every read returns a status word instead of array data. That word has the complement of bit 7 of the loaded word and a bit 6 that alternates on every read, so software can poll for completion. A `protected_i` input comes from a separate protection detector. While it is high, no program or erase can begin.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the block is in read mode, with `busy`, `done`, `arr_prog` and `arr_erase` low and `rdata` equal to 0000h.
- R2: In read mode, a read cycle (`rd_en` high, `wr_en` low) at address A puts the array word at A on `rdata` one clock later. `rdata` holds its value until the next read. A write in the same cycle takes priority and the read is dropped.
- R3: A write whose low data byte is 90h enters identification mode. There, a read at address 0 returns 0062h, at address 1 returns 0017h, and at any other address returns 0000h. Writing FFFFh, or an accepted 20h or 10h setup, leaves the mode. Any other byte is ignored.
- R4: A write whose low byte is 10h, followed by any further write other than FFFFh, starts a word program. `arr_prog` is then high for exactly PROG_CYCLES clocks. During that time `arr_addr` and `arr_wdata` hold the second write's address and data.
- R5: A write whose low byte is 20h, followed by a write whose low byte is D0h, starts a sector erase. `arr_erase` is then high for exactly ERASE_CYCLES clocks. During that time `arr_addr` holds the sector base, which is address bits 15..7 of the execute write with bits 6..0 cleared, so each sector is 128 words.
- R6: A write of FFFFh after either setup write returns to read mode without starting an operation. The array stays unchanged.
- R7: After an erase setup, a write whose low byte is not D0h (and is not FFFFh) returns to read mode without starting an operation. A D0h write in read mode is ignored.
- R8: While busy, every read returns a status word: bits 15..8 and 5..0 are zero, bit 7 is the complement of bit 7 of the loaded word (the program data, or FFFFh for an erase), and bit 6 is 0 on the first read of the operation and alternates on each read after that.
- R9: While busy, writes are ignored. The one exception is a write of FFFFh during an erase, which ends the erase at that clock edge with no `done` pulse.
- R10: When the operation count expires, `busy` falls and `done` is high for exactly one clock, the first clock after `busy` falls. Reads then return true array data.
- R11: While `protected_i` is high, 10h and 20h setup writes are ignored. An execute or address/data write that arrives while it is high returns the block to read mode without starting an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read cycle strobe |
| wr_en | input | 1 | Write cycle strobe |
| addr | input | 16 | Bus word address |
| wdata | input | 16 | Bus write data |
| protected_i | input | 1 | Write protection active |
| arr_rdata | input | 16 | Array word at `arr_addr` (combinational) |
| rdata | output | 16 | Registered read data |
| busy | output | 1 | Program or erase in progress |
| done | output | 1 | One-cycle completion pulse |
| arr_prog | output | 1 | Program strobe to the array |
| arr_erase | output | 1 | Sector erase strobe to the array |
| arr_addr | output | 16 | Array address (operation address while busy, bus address otherwise) |
| arr_wdata | output | 16 | Word to program (FFFFh for erase) |

## Verification
The command decoder is exercised with several kinds of write sequence: every recognised command byte, unrecognised bytes in read, identification and erase-setup modes, the abort word after each setup, and stray execute bytes. These separate a decoder that really tracks its mode from one that reacts to single bytes. Program and erase are each run to completion with status polling on a word whose bit 7 is 0 and on erased data whose bit 7 is 1. This tells the polling complement apart from plain data, and shows the alternating bit as distinct from a constant. Other cases cover an erase abort, a write refused while busy, and protection raised both before a setup and between setup and execute. Reads afterwards at the sector edges and next to them confirm that only the selected 128 words changed.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    localparam int WORD_W = 16;
    localparam int SECT_LSB = 7;

    localparam logic [7:0]        BYTE_ERASE_SETUP = 8'h20;
    localparam logic [7:0]        BYTE_PROG_SETUP  = 8'h10;
    localparam logic [7:0]        BYTE_ERASE_GO    = 8'hD0;
    localparam logic [7:0]        BYTE_IDENT       = 8'h90;
    localparam logic [WORD_W-1:0] WORD_ABORT       = 16'hFFFF;
    localparam logic [WORD_W-1:0] ID_MAKER         = 16'h0062;
    localparam logic [WORD_W-1:0] ID_PART          = 16'h0017;

    typedef enum logic [2:0] {
        M_READ,
        M_IDENT,
        M_ERASE_SU,
        M_PROG_SU,
        M_ERASING,
        M_PROGRAMMING
    } mode_e;

    typedef enum logic [2:0] {
        K_ABORT,
        K_ERASE_SU,
        K_PROG_SU,
        K_ERASE_GO,
        K_IDENT,
        K_OTHER
    } cmd_e;

    typedef struct packed {
        logic              is_erase;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } op_t;

    function automatic cmd_e classify(input logic [WORD_W-1:0] w);
        cmd_e k;
        if (w == WORD_ABORT)               k = K_ABORT;
        else if (w[7:0] == BYTE_ERASE_SU_f()) k = K_ERASE_SU;
        else if (w[7:0] == BYTE_PROG_SETUP) k = K_PROG_SU;
        else if (w[7:0] == BYTE_ERASE_GO)  k = K_ERASE_GO;
        else if (w[7:0] == BYTE_IDENT)     k = K_IDENT;
        else                               k = K_OTHER;
        return k;
    endfunction

    function automatic logic [7:0] BYTE_ERASE_SU_f();
        return BYTE_ERASE_SETUP;
    endfunction

    function automatic logic is_busy_mode(input mode_e m);
        return (m == M_ERASING) || (m == M_PROGRAMMING);
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_ctrl_pkg::*;
(
    input  mode_e              mode,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               protected_i,
    output mode_e              next_mode,
    output logic               start,
    output op_t                start_op,
    output logic               cancel
);
    localparam logic [WORD_W-1:0] SECT_MASK = {{(WORD_W-SECT_LSB){1'b1}}, {SECT_LSB{1'b0}}};

    cmd_e cmd;

    always_comb begin
        cmd       = classify(wdata);
        next_mode = mode;
        start     = 1'b0;
        cancel    = 1'b0;
        start_op  = '{is_erase: 1'b0, addr: addr, data: wdata};
        if (wr_en) begin
            unique case (mode)
                M_READ, M_IDENT: begin
                    unique case (cmd)
                        K_ABORT:    next_mode = M_READ;
                        K_IDENT:    next_mode = M_IDENT;
                        K_ERASE_SU: if (!protected_i) next_mode = M_ERASE_SU;
                        K_PROG_SU:  if (!protected_i) next_mode = M_PROG_SU;
                        default:    next_mode = mode;
                    endcase
                end
                M_ERASE_SU: begin
                    if (cmd == K_ERASE_GO && !protected_i) begin
                        next_mode = M_ERASING;
                        start     = 1'b1;
                        start_op  = '{is_erase: 1'b1, addr: addr & SECT_MASK, data: WORD_ABORT};
                    end else begin
                        next_mode = M_READ;
                    end
                end
                M_PROG_SU: begin
                    if (cmd == K_ABORT || protected_i) begin
                        next_mode = M_READ;
                    end else begin
                        next_mode = M_PROGRAMMING;
                        start     = 1'b1;
                    end
                end
                M_ERASING: begin
                    if (cmd == K_ABORT) begin
                        next_mode = M_READ;
                        cancel    = 1'b1;
                    end
                end
                default: next_mode = mode;
            endcase
        end
    end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int PROG_CYCLES  = 2000,
    parameter int ERASE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_erase,
    input  logic running,
    output logic expire
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= start_erase ? ERASE_LOAD : PROG_LOAD;
        end else if (running && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = running && (cnt == '0);
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
    import flash_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  logic              busy,
    input  logic              ident,
    input  logic              start,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] arr_rdata,
    input  logic [WORD_W-1:0] loaded,
    output logic [WORD_W-1:0] rdata
);
    logic tog;

    function automatic logic [WORD_W-1:0] ident_word(input logic [WORD_W-1:0] a);
        if (a == 16'h0000)      return ID_MAKER;
        else if (a == 16'h0001) return ID_PART;
        else                    return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else begin
            if (start) tog <= 1'b0;
            if (rd_go) begin
                if (busy) begin
                    rdata <= {8'h00, ~loaded[7], tog, 6'b0};
                    tog   <= ~tog;
                end else if (ident) begin
                    rdata <= ident_word(addr);
                end else begin
                    rdata <= arr_rdata;
                end
            end
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int PROG_CYCLES  = 2000,
    parameter int ERASE_CYCLES = 200000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    input  logic        protected_i,
    input  logic [15:0] arr_rdata,
    output logic [15:0] rdata,
    output logic        busy,
    output logic        done,
    output logic        arr_prog,
    output logic        arr_erase,
    output logic [15:0] arr_addr,
    output logic [15:0] arr_wdata
);
    mode_e mode, next_mode;
    op_t   op, start_op;
    logic  start, cancel, expire;

    flash_cmd_decode u_dec (
        .mode        (mode),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .protected_i (protected_i),
        .next_mode   (next_mode),
        .start       (start),
        .start_op    (start_op),
        .cancel      (cancel)
    );

    flash_op_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_erase (start_op.is_erase),
        .running     (busy),
        .expire      (expire)
    );

    flash_read_path u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_go     (rd_en && !wr_en),
        .busy      (busy),
        .ident     (mode == M_IDENT),
        .start     (start),
        .addr      (addr),
        .arr_rdata (arr_rdata),
        .loaded    (op.data),
        .rdata     (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= M_READ;
            op   <= '0;
            done <= 1'b0;
        end else begin
            done <= expire && !cancel;
            if (expire) mode <= M_READ;
            else        mode <= next_mode;
            if (start)  op <= start_op;
        end
    end

    assign busy      = is_busy_mode(mode);
    assign arr_prog  = (mode == M_PROGRAMMING);
    assign arr_erase = (mode == M_ERASING);
    assign arr_addr  = busy ? op.addr : addr;
    assign arr_wdata = op.data;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wdata,
    input logic        protected_i,
    input logic        busy,
    input logic        done,
    input logic        arr_prog,
    input logic        arr_erase,
    input logic [15:0] arr_addr,
    input logic [15:0] arr_wdata
);
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arr_prog, arr_erase}));

    assert_prog_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (arr_prog && $past(arr_prog)) |-> ($stable(arr_addr) && $stable(arr_wdata)));

    assert_erase_align_R5: assert property (@(posedge clk) disable iff (rst)
        arr_erase |-> (arr_addr[6:0] == 7'd0));

    assert_start_by_write_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en && !protected_i));

    assert_protect_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en && protected_i) |=> !busy);

    assert_erase_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (arr_erase && wr_en && wdata == 16'hFFFF) |=> (!busy && !done));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (.*);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int PROG_CYC  = 12;
    localparam int ERASE_CYC = 40;
    localparam int MEMW      = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0, protected_i = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] arr_rdata, rdata, arr_addr, arr_wdata;
    logic        busy, done, arr_prog, arr_erase;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [15:0] mem [MEMW];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_ctrl #(.PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)) dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .protected_i(protected_i), .arr_rdata(arr_rdata),
        .rdata(rdata), .busy(busy), .done(done), .arr_prog(arr_prog),
        .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    function automatic logic [15:0] ini(input logic [15:0] a);
        return {6'b0, a[9:0]} ^ 16'hA5C3;
    endfunction

    // array model
    assign arr_rdata = mem[arr_addr[9:0]];
    always @(posedge clk) begin
        if (arr_prog) mem[arr_addr[9:0]] <= arr_wdata;
        if (arr_erase)
            for (int i = 0; i < 128; i++) mem[arr_addr[9:0] + 10'(i)] <= 16'hFFFF;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    endtask

    // vector: wr, use_init, req, addr, data-or-expected
    localparam int NV = 22;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'd2, 16'h0010, 16'h0000},  // R2 array read
        {1'b0, 1'b1, 4'd2, 16'h03FF, 16'h0000},  // R2
        {1'b1, 1'b0, 4'd3, 16'h0000, 16'h0090},  // R3 enter ident
        {1'b0, 1'b0, 4'd3, 16'h0000, 16'h0062},  // R3
        {1'b0, 1'b0, 4'd3, 16'h0001, 16'h0017},  // R3
        {1'b0, 1'b0, 4'd3, 16'h0005, 16'h0000},  // R3
        {1'b1, 1'b0, 4'd3, 16'h0000, 16'h0033},  // R3 unknown byte ignored
        {1'b0, 1'b0, 4'd3, 16'h0000, 16'h0062},  // R3 still ident
        {1'b1, 1'b0, 4'd3, 16'h0000, 16'hFFFF},  // R3 leave
        {1'b0, 1'b1, 4'd3, 16'h0001, 16'h0000},  // R3 back to array
        {1'b1, 1'b0, 4'd3, 16'h0000, 16'h0090},  // R3
        {1'b1, 1'b0, 4'd6, 16'h0000, 16'h0020},  // R3 setup leaves ident
        {1'b1, 1'b0, 4'd6, 16'h0080, 16'hFFFF},  // R6 abort erase setup
        {1'b0, 1'b1, 4'd6, 16'h0080, 16'h0000},  // R6
        {1'b1, 1'b0, 4'd6, 16'h0000, 16'h0010},  // R6
        {1'b1, 1'b0, 4'd6, 16'h0020, 16'hFFFF},  // R6 abort program setup
        {1'b0, 1'b1, 4'd6, 16'h0020, 16'h0000},  // R6
        {1'b1, 1'b0, 4'd7, 16'h0000, 16'h0020},  // R7
        {1'b1, 1'b0, 4'd7, 16'h0100, 16'h0055},  // R7 bad execute
        {1'b0, 1'b1, 4'd7, 16'h0100, 16'h0000},  // R7
        {1'b1, 1'b0, 4'd7, 16'h0100, 16'h00D0},  // R7 stray execute
        {1'b0, 1'b1, 4'd7, 16'h0100, 16'h0000}   // R7
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R10 act=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int c0;
        for (int i = 0; i < MEMW; i++) mem[i] = ini(16'(i));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {15'b0, busy}, 16'h0);
        chk("R1 done", {15'b0, done}, 16'h0);
        chk("R1 strobes", {14'b0, arr_prog, arr_erase}, 16'h0);
        chk("R1 rdata", rdata, 16'h0000);

        for (int n = 0; n < NV; n++) begin
            logic [37:0] e;
            string tag;
            e = VEC[n];
            tag = $sformatf("R%0d vec%0d", e[35:32], n);
            if (e[37]) begin
                do_write(e[31:16], e[15:0]);
                chk(tag, {15'b0, busy}, 16'h0);
            end else begin
                do_read(e[31:16], v);
                chk(tag, v, e[36] ? ini(e[31:16]) : e[15:0]);
            end
        end

        // R4 program with R8 polling, R9 ignored write, R10 completion
        do_write(16'h0000, 16'h0010);
        do_write(16'h0055, 16'h1234);
        c0 = cyc;
        chk("R4 busy", {15'b0, busy}, 16'h1);
        chk("R4 arr_prog", {15'b0, arr_prog}, 16'h1);
        chk("R4 arr_addr", arr_addr, 16'h0055);
        chk("R4 arr_wdata", arr_wdata, 16'h1234);
        do_read(16'h0055, v);
        chk("R8 poll1", v, 16'h0080);
        do_read(16'h0055, v);
        chk("R8 poll2", v, 16'h00C0);
        do_write(16'h0055, 16'hFFFF);
        chk("R9 busy after write", {15'b0, busy}, 16'h1);
        wait_done();
        chk("R4 duration", 16'(cyc - c0), 16'(PROG_CYC));
        chk("R10 busy low at done", {15'b0, busy}, 16'h0);
        @(negedge clk);
        chk("R10 done single", {15'b0, done}, 16'h0);
        do_read(16'h0055, v);
        chk("R10 true data", v, 16'h1234);

        // R5 erase of sector 2
        do_write(16'h0000, 16'h0020);
        do_write(16'h0105, 16'h00D0);
        c0 = cyc;
        chk("R5 arr_erase", {15'b0, arr_erase}, 16'h1);
        chk("R5 arr_addr", arr_addr, 16'h0100);
        do_read(16'h0105, v);
        chk("R8 erase poll1", v, 16'h0000);
        do_read(16'h0300, v);
        chk("R8 erase poll2", v, 16'h0040);
        wait_done();
        chk("R5 duration", 16'(cyc - c0), 16'(ERASE_CYC));
        do_read(16'h0100, v);  chk("R5 first", v, 16'hFFFF);
        do_read(16'h017F, v);  chk("R5 last", v, 16'hFFFF);
        do_read(16'h0180, v);  chk("R5 next sector", v, ini(16'h0180));
        do_read(16'h00FF, v);  chk("R5 prev sector", v, ini(16'h00FF));
        do_read(16'h0055, v);  chk("R5 other word", v, 16'h1234);

        // R9 erase abort
        do_write(16'h0000, 16'h0020);
        do_write(16'h0200, 16'h00D0);
        repeat (3) @(negedge clk);
        do_write(16'h0000, 16'hFFFF);
        chk("R9 abort busy", {15'b0, busy}, 16'h0);
        chk("R9 abort done", {15'b0, done}, 16'h0);
        @(negedge clk);
        chk("R9 no late done", {15'b0, done}, 16'h0);
        do_read(16'h0300, v);
        chk("R9 read mode", v, ini(16'h0300));

        // R11 protection
        protected_i = 1'b1;
        do_write(16'h0000, 16'h0010);
        do_write(16'h0040, 16'h0000);
        chk("R11 prog refused", {15'b0, busy}, 16'h0);
        do_read(16'h0040, v);
        chk("R11 word kept", v, ini(16'h0040));
        do_write(16'h0000, 16'h0020);
        do_write(16'h0300, 16'h00D0);
        chk("R11 erase refused", {15'b0, busy}, 16'h0);
        protected_i = 1'b0;
        do_write(16'h0000, 16'h0010);
        protected_i = 1'b1;
        do_write(16'h0041, 16'h0000);
        chk("R11 late protect", {15'b0, busy}, 16'h0);
        protected_i = 1'b0;
        do_write(16'h0042, 16'h0000);
        chk("R11 back in read", {15'b0, busy}, 16'h0);
        do_read(16'h0041, v);
        chk("R11 word kept 2", v, ini(16'h0041));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule